// File: doc/BRIEF.md
# Up/down auto-reload timer with clock output

This block is a 16-bit timer/counter with a 16-bit reload/capture register and one control register, all reached over a byte-wide register bus. It has three uses. In timer mode it advances on an internal tick enable. In counter mode it advances on falling edges of a count pin. In either mode it can also capture or reload on a falling edge of an external pin, or count up or down under that pin's level.

A third use turns the counter into a clock generator with 50% duty. The counter advances on a fast enable. Each overflow reloads the counter and toggles a clock output. The 16-bit reload value therefore sets the output period.

Both external pins pass through a two-flop synchroniser, and edges are found on the synchronised samples. The two status flags are set by hardware and are cleared only by writes over the bus. When software writes a counter byte in the same cycle as a hardware update, the written byte wins.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset every readable register holds 0, and `ovf_flag`, `ext_flag`, `irq` and `clk_out` are 0.
- R2: Address 0 is the control register. Its bits are: 0 run, 1 count-pin select, 2 capture select, 3 external enable, 4 up/down enable, 5 clock-out enable, 6 overflow flag, 7 external flag. Addresses 1 and 2 are the counter low and high bytes. Addresses 3 and 4 are the reload low and high bytes. A written value reads back one cycle later through the combinational `rd_data`.
- R3: In timer mode (bit 1 = 0) with run set, the counter gains one for each cycle in which `tick_en` is high. With run clear it holds.
- R4: In counter mode (bit 1 = 1) the counter gains one for each falling edge of `cnt_pin`, three rising clock edges after the pin falls, and `tick_en` has no effect.
- R5: Counting up, a step taken at FFFFh loads the reload value instead and sets the overflow flag. A set overflow flag drives `irq` high.
- R6: With up/down enabled and `ext_pin` low, the counter steps down. A step taken while the count equals the reload value loads FFFFh and sets the overflow flag.
- R7: With up/down enabled, the external flag toggles on every overflow or underflow and does not drive `irq`.
- R8: With up/down disabled, external enable set and capture select set, a falling edge of `ext_pin` copies the count into the reload register, sets the external flag and raises `irq`.
- R9: With up/down disabled, external enable set and capture select clear, a falling edge of `ext_pin` loads the reload value into the counter and sets the external flag.
- R10: With external enable clear, falling edges of `ext_pin` change neither the counter, nor the reload register, nor the external flag.
- R11: With clock-out enabled, the counter advances on `fast_en`. Each overflow reloads the counter and toggles `clk_out`, and the overflow flag stays clear.
- R12: A set flag stays set until a control write puts 0 in its bit position.
- R13: A bus write to a counter byte in the same cycle as a hardware update takes that byte from the bus; the other byte takes the hardware's next value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tick_en | input | 1 | Internal time base enable (timer mode) |
| fast_en | input | 1 | Advance enable in clock-out mode |
| cnt_pin | input | 1 | Count input, asynchronous |
| ext_pin | input | 1 | Capture/reload/direction input, asynchronous |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External event / toggle flag |
| clk_out | output | 1 | Generated clock |

## Verification
Bus writes and `tick_en` or `fast_en` steps take effect at the next rising edge, so the bench drives each stimulus after a falling edge and reads back at the following falling edge. An edge on `cnt_pin` or `ext_pin` passes two synchroniser flops and one edge-detect flop, so its effect is due after the third rising edge. The bench waits exactly three falling edges after moving a pin before it checks. `rd_data` is combinational, so each read samples one time unit after the address is set, well clear of any clock edge.

// File: rtl/urt_pkg.sv
`timescale 1ns/1ps
package urt_pkg;
   // Control register layout (bits 0..5 configuration, 6..7 flags)
   typedef struct packed {
      logic clk_out_en;
      logic updown_en;
      logic ext_en;
      logic capture_sel;
      logic count_pin_sel;
      logic run;
   } cfg_t;

   localparam int CFG_W    = 6;
   localparam int OVF_BIT  = 6;
   localparam int EXTF_BIT = 7;
   localparam int CTRL_W   = 8;
   localparam int PIN_CNT  = 0;
   localparam int PIN_EXT  = 1;
   localparam int NUM_PINS = 2;
endpackage

// File: rtl/urt_sync.sv
`timescale 1ns/1ps
module urt_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_lvl,
   output logic [WIDTH-1:0] pin_fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("urt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;
   logic [WIDTH-1:0]             prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q[s] <= '1;
         end else if (s == 0) begin
            stg_q[s] <= pin_in;
         end else begin
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= stg_q[STAGES-1];
   end

   assign pin_lvl  = stg_q[STAGES-1];
   assign pin_fall = prev_q & ~stg_q[STAGES-1];
endmodule

// File: rtl/urt_regif.sv
`timescale 1ns/1ps
module urt_regif
   import urt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [BUS_W-1:0]             wr_data,
   output logic [BUS_W-1:0]             rd_data,
   input  logic [CNT_W-1:0]             cnt_q,
   input  logic [CNT_W-1:0]             rld_q,
   input  logic                         ovf_q,
   input  logic                         ext_q,
   output cfg_t                         cfg,
   output logic                         ctrl_wr,
   output logic [CNT_W/BUS_W-1:0]       cnt_be,
   output logic [CNT_W/BUS_W-1:0]       rld_be
);
   localparam int NBYTES   = CNT_W / BUS_W;
   localparam int CNT_BASE = 1;
   localparam int RLD_BASE = CNT_BASE + NBYTES;

   cfg_t cfg_q;

   assign ctrl_wr = wr_en && (addr == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (ctrl_wr) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
   end
   assign cfg = cfg_q;

   for (genvar b = 0; b < NBYTES; b++) begin : g_strobe
      assign cnt_be[b] = wr_en && (addr == ADDR_W'(CNT_BASE + b));
      assign rld_be[b] = wr_en && (addr == ADDR_W'(RLD_BASE + b));
   end

   always_comb begin
      rd_data = '0;
      if (addr == '0) begin
         rd_data = BUS_W'({ext_q, ovf_q, cfg_q});
      end
      for (int b = 0; b < NBYTES; b++) begin
         if (addr == ADDR_W'(CNT_BASE + b)) rd_data = cnt_q[b*BUS_W +: BUS_W];
         if (addr == ADDR_W'(RLD_BASE + b)) rd_data = rld_q[b*BUS_W +: BUS_W];
      end
   end
endmodule

// File: rtl/urt_core.sv
`timescale 1ns/1ps
module urt_core
   import urt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  cfg_t                   cfg,
   input  logic                   tick_en,
   input  logic                   fast_en,
   input  logic                   cnt_fall,
   input  logic                   ext_fall,
   input  logic                   ext_lvl,
   input  logic                   ctrl_wr,
   input  logic [1:0]             flag_wdata,
   input  logic [CNT_W/BUS_W-1:0] cnt_be,
   input  logic [CNT_W/BUS_W-1:0] rld_be,
   input  logic [BUS_W-1:0]       wr_data,
   output logic [CNT_W-1:0]       cnt_q,
   output logic [CNT_W-1:0]       rld_q,
   output logic                   ovf_q,
   output logic                   ext_q,
   output logic                   clk_out_q,
   output logic                   irq
);
   localparam int NBYTES = CNT_W / BUS_W;
   localparam logic [CNT_W-1:0] TOP = '1;

   logic             step_en, count_down, at_top, at_floor, wrap, ext_evt;
   logic             ovf_base, ext_base;
   logic [CNT_W-1:0] step_val, hw_cnt, hw_rld, cnt_d, rld_d;

   // Step source: clock-out mode uses the fast enable, otherwise pin or tick
   always_comb begin
      if (!cfg.run)               step_en = 1'b0;
      else if (cfg.clk_out_en)    step_en = fast_en;
      else if (cfg.count_pin_sel) step_en = cnt_fall;
      else                        step_en = tick_en;
   end

   assign count_down = cfg.updown_en && !cfg.clk_out_en && !ext_lvl;
   assign at_top     = (cnt_q == TOP);
   assign at_floor   = (cnt_q == rld_q);
   assign wrap       = step_en && (count_down ? at_floor : at_top);
   assign ext_evt    = ext_fall && cfg.ext_en && !cfg.updown_en;

   always_comb begin
      if (count_down) step_val = at_floor ? TOP   : cnt_q - 1'b1;
      else            step_val = at_top   ? rld_q : cnt_q + 1'b1;
   end

   always_comb begin
      if (ext_evt && !cfg.capture_sel) hw_cnt = rld_q;
      else if (step_en)                hw_cnt = step_val;
      else                             hw_cnt = cnt_q;
      hw_rld = (ext_evt && cfg.capture_sel) ? cnt_q : rld_q;
   end

   // Bus writes win per byte over the hardware update
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign cnt_d[b*BUS_W +: BUS_W] = cnt_be[b] ? wr_data : hw_cnt[b*BUS_W +: BUS_W];
      assign rld_d[b*BUS_W +: BUS_W] = rld_be[b] ? wr_data : hw_rld[b*BUS_W +: BUS_W];
   end

   assign ovf_base = ctrl_wr ? flag_wdata[0] : ovf_q;
   assign ext_base = ctrl_wr ? flag_wdata[1] : ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rld_q     <= '0;
         ovf_q     <= 1'b0;
         ext_q     <= 1'b0;
         clk_out_q <= 1'b0;
      end else begin
         cnt_q     <= cnt_d;
         rld_q     <= rld_d;
         ovf_q     <= ovf_base | (wrap && !cfg.clk_out_en);
         ext_q     <= (ext_base ^ (wrap && cfg.updown_en && !cfg.clk_out_en)) | ext_evt;
         clk_out_q <= clk_out_q ^ (wrap && cfg.clk_out_en);
      end
   end

   assign irq = ovf_q | (ext_q & ~cfg.updown_en);
endmodule

// File: rtl/updown_reload_timer.sv
`timescale 1ns/1ps
module updown_reload_timer
   import urt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              tick_en,
   input  logic              fast_en,
   input  logic              cnt_pin,
   input  logic              ext_pin,
   output logic              irq,
   output logic              ovf_flag,
   output logic              ext_flag,
   output logic              clk_out
);
   localparam int NBYTES = CNT_W / BUS_W;

   if (BUS_W < CTRL_W) begin : g_bad_bus
      $error("updown_reload_timer: BUS_W must hold the control register");
   end
   if (CNT_W % BUS_W != 0) begin : g_bad_cnt
      $error("updown_reload_timer: CNT_W must be a multiple of BUS_W");
   end
   if ((2*NBYTES + 1) > (1 << ADDR_W)) begin : g_bad_addr
      $error("updown_reload_timer: ADDR_W too small for the register map");
   end

   cfg_t                cfg;
   logic                ctrl_wr;
   logic [NBYTES-1:0]   cnt_be, rld_be;
   logic [CNT_W-1:0]    cnt_q, rld_q;
   logic [NUM_PINS-1:0] pin_lvl, pin_fall;
   logic                ext_lvl;
   logic                unused_cnt_lvl;

   urt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   ({ext_pin, cnt_pin}),
      .pin_lvl  (pin_lvl),
      .pin_fall (pin_fall)
   );
   assign ext_lvl        = pin_lvl[PIN_EXT];
   assign unused_cnt_lvl = pin_lvl[PIN_CNT];

   urt_regif #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_regif (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .cnt_q   (cnt_q),
      .rld_q   (rld_q),
      .ovf_q   (ovf_flag),
      .ext_q   (ext_flag),
      .cfg     (cfg),
      .ctrl_wr (ctrl_wr),
      .cnt_be  (cnt_be),
      .rld_be  (rld_be)
   );

   urt_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .tick_en    (tick_en),
      .fast_en    (fast_en),
      .cnt_fall   (pin_fall[PIN_CNT]),
      .ext_fall   (pin_fall[PIN_EXT]),
      .ext_lvl    (ext_lvl),
      .ctrl_wr    (ctrl_wr),
      .flag_wdata ({wr_data[EXTF_BIT], wr_data[OVF_BIT]}),
      .cnt_be     (cnt_be),
      .rld_be     (rld_be),
      .wr_data    (wr_data),
      .cnt_q      (cnt_q),
      .rld_q      (rld_q),
      .ovf_q      (ovf_flag),
      .ext_q      (ext_flag),
      .clk_out_q  (clk_out),
      .irq        (irq)
   );
endmodule

// File: rtl/urt_checker.sv
`timescale 1ns/1ps
module urt_checker
   import urt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NBYTES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input cfg_t              cfg,
   input logic              ctrl_wr,
   input logic [NBYTES-1:0] cnt_be,
   input logic              tick_en,
   input logic              ext_lvl,
   input logic              cnt_fall,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  rld_q,
   input logic              ovf_flag,
   input logic              ext_flag,
   input logic              clk_out,
   input logic              irq
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R3: stopped timer holds its count
   p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.run && !cfg.ext_en && cnt_be == '0) |=> $stable(cnt_q));

   // R4: in counter mode nothing but a pin fall moves the count
   p_counter_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.count_pin_sel && !cfg.clk_out_en && !cfg.ext_en && !cnt_fall && cnt_be == '0)
      |=> $stable(cnt_q));

   // R5: upward step at the top reloads and flags
   p_up_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.run && !cfg.count_pin_sel && !cfg.clk_out_en && !cfg.updown_en && !cfg.ext_en
       && tick_en && cnt_q == TOP && cnt_be == '0)
      |=> (cnt_q == $past(rld_q) && ovf_flag));

   // R6: downward step at the reload value loads all ones
   p_down_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.run && !cfg.count_pin_sel && !cfg.clk_out_en && cfg.updown_en && !ext_lvl
       && tick_en && cnt_q == rld_q && cnt_be == '0)
      |=> (cnt_q == TOP && ovf_flag));

   // R7: toggle flag never requests an interrupt in up/down mode
   p_toggle_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.updown_en && !ovf_flag) |-> !irq);

   // R10: disabled external input leaves the external flag clear
   p_ext_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.ext_en && !cfg.updown_en && !ext_flag && !ctrl_wr) |=> !ext_flag);

   // R11: clock-out mode never raises the overflow flag
   p_clkout_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.clk_out_en && !ovf_flag && !ctrl_wr) |=> !ovf_flag);

   // R11: the clock output moves only in clock-out mode
   p_clkout_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.clk_out_en |=> $stable(clk_out));

   // R12: flags are sticky without a control write
   p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ctrl_wr) |=> ovf_flag);
endmodule

bind updown_reload_timer urt_checker #(.CNT_W(CNT_W), .NBYTES(NBYTES)) i_urt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg      (cfg),
   .ctrl_wr  (ctrl_wr),
   .cnt_be   (cnt_be),
   .tick_en  (tick_en),
   .ext_lvl  (ext_lvl),
   .cnt_fall (pin_fall[0]),
   .cnt_q    (cnt_q),
   .rld_q    (rld_q),
   .ovf_flag (ovf_flag),
   .ext_flag (ext_flag),
   .clk_out  (clk_out),
   .irq      (irq)
);

// File: tb/test_updown_reload_timer.sv
`timescale 1ns/1ps
module test_updown_reload_timer;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       tick_en = 1'b0;
   logic       fast_en = 1'b0;
   logic       cnt_pin = 1'b1;
   logic       ext_pin = 1'b1;
   logic       irq, ovf_flag, ext_flag, clk_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updown_reload_timer i_updown_reload_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .tick_en(tick_en), .fast_en(fast_en), .cnt_pin(cnt_pin),
      .ext_pin(ext_pin), .irq(irq), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
      .clk_out(clk_out)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_RLD = 3'd3;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] d);
      wr(a, d[7:0]);
      wr(a + 3'd1, d[15:8]);
   endtask

   task automatic rd16(input logic [2:0] a, output logic [15:0] d);
      addr = a;     #1; d[7:0]  = rd_data;
      addr = a + 1; #1; d[15:8] = rd_data;
   endtask

   task automatic rd8(input logic [2:0] a, output logic [7:0] d);
      addr = a; #1; d = rd_data;
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic ext_fall_edge;
      @(negedge clk); ext_pin = 1'b0;
      cycles(3);
   endtask

   task automatic ext_restore;
      ext_pin = 1'b1;
      cycles(3);
   endtask

   task automatic t_reset;
      logic [15:0] v; logic [7:0] c;
      rd8(A_CTRL, c);  chk("R1 ctrl", c, 8'h00);
      rd16(A_CNT, v);  chk("R1 count", v, 16'h0000);
      rd16(A_RLD, v);  chk("R1 reload", v, 16'h0000);
      chk("R1 outputs", {irq, ovf_flag, ext_flag, clk_out}, 4'b0000);
   endtask

   task automatic t_regs;
      logic [15:0] v; logic [7:0] c;
      wr(A_CTRL, 8'h2C);
      rd8(A_CTRL, c);  chk("R2 ctrl readback", c, 8'h2C);
      wr(A_CTRL, 8'h00);
      wr16(A_CNT, 16'h1234);
      wr16(A_RLD, 16'hABCD);
      rd16(A_CNT, v);  chk("R2 count readback", v, 16'h1234);
      rd16(A_RLD, v);  chk("R2 reload readback", v, 16'hABCD);
   endtask

   task automatic t_timer;
      logic [15:0] v;
      wr16(A_CNT, 16'h0010);
      wr(A_CTRL, 8'h01);
      tick(5);
      rd16(A_CNT, v);  chk("R3 five ticks", v, 16'h0015);
      wr(A_CTRL, 8'h00);
      tick(3);
      rd16(A_CNT, v);  chk("R3 halted", v, 16'h0015);
   endtask

   task automatic t_counter;
      logic [15:0] v;
      wr16(A_CNT, 16'h0000);
      wr(A_CTRL, 8'h03);
      tick(2);
      rd16(A_CNT, v);  chk("R4 tick ignored", v, 16'h0000);
      @(negedge clk); cnt_pin = 1'b0;
      cycles(2);
      rd16(A_CNT, v);  chk("R4 not yet", v, 16'h0000);
      cycles(1);
      rd16(A_CNT, v);  chk("R4 third edge", v, 16'h0001);
      cnt_pin = 1'b1; cycles(3);
      for (int i = 0; i < 2; i++) begin
         cnt_pin = 1'b0; cycles(3);
         cnt_pin = 1'b1; cycles(3);
      end
      rd16(A_CNT, v);  chk("R4 three falls", v, 16'h0003);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_overflow;
      logic [15:0] v;
      wr16(A_RLD, 16'h8000);
      wr16(A_CNT, 16'hFFFE);
      wr(A_CTRL, 8'h01);
      tick(1);
      rd16(A_CNT, v);  chk("R5 at top", v, 16'hFFFF);
      chk("R5 no flag yet", ovf_flag, 1'b0);
      tick(1);
      rd16(A_CNT, v);  chk("R5 reload", v, 16'h8000);
      chk("R5 flag and irq", {ovf_flag, irq}, 2'b11);
      tick(3);
      chk("R12 flag sticky", ovf_flag, 1'b1);
      wr(A_CTRL, 8'h01);
      chk("R12 cleared by write", {ovf_flag, irq}, 2'b00);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_updown;
      logic [15:0] v;
      wr16(A_RLD, 16'h0100);
      wr16(A_CNT, 16'h0102);
      @(negedge clk); ext_pin = 1'b0; cycles(3);
      wr(A_CTRL, 8'h11);
      tick(2);
      rd16(A_CNT, v);  chk("R6 down twice", v, 16'h0100);
      chk("R6 no flag at floor", ovf_flag, 1'b0);
      tick(1);
      rd16(A_CNT, v);  chk("R6 underflow", v, 16'hFFFF);
      chk("R6 flag", ovf_flag, 1'b1);
      chk("R7 toggled on", ext_flag, 1'b1);
      wr(A_CTRL, 8'h91);
      chk("R7 toggle flag no irq", {ext_flag, ovf_flag, irq}, 3'b100);
      ext_restore();
      tick(1);
      rd16(A_CNT, v);  chk("R5 up overflow in up/down", v, 16'h0100);
      chk("R7 toggled off", {ext_flag, ovf_flag}, 2'b01);
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_capture;
      logic [15:0] v;
      wr16(A_CNT, 16'h4321);
      wr16(A_RLD, 16'h0000);
      wr(A_CTRL, 8'h0D);
      ext_fall_edge();
      rd16(A_RLD, v);  chk("R8 captured", v, 16'h4321);
      chk("R8 flag and irq", {ext_flag, irq}, 2'b11);
      ext_restore();
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_ext_reload;
      logic [15:0] v;
      wr16(A_RLD, 16'h0777);
      wr16(A_CNT, 16'h0001);
      wr(A_CTRL, 8'h09);
      ext_fall_edge();
      rd16(A_CNT, v);  chk("R9 reloaded", v, 16'h0777);
      chk("R9 flag", ext_flag, 1'b1);
      ext_restore();
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_ext_off;
      logic [15:0] v;
      wr16(A_CNT, 16'h2222);
      wr16(A_RLD, 16'h1111);
      wr(A_CTRL, 8'h05);
      ext_fall_edge();
      rd16(A_RLD, v);  chk("R10 reload kept", v, 16'h1111);
      rd16(A_CNT, v);  chk("R10 count kept", v, 16'h2222);
      chk("R10 flag clear", ext_flag, 1'b0);
      ext_restore();
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_clkout;
      logic [15:0] v;
      wr16(A_RLD, 16'hFFFE);
      wr16(A_CNT, 16'hFFFE);
      wr(A_CTRL, 8'h21);
      @(negedge clk); fast_en = 1'b1;
      cycles(2);
      chk("R11 first toggle", clk_out, 1'b1);
      rd16(A_CNT, v);  chk("R11 reloaded", v, 16'hFFFE);
      chk("R11 no flag", {ovf_flag, irq}, 2'b00);
      cycles(2);
      chk("R11 second toggle", clk_out, 1'b0);
      fast_en = 1'b0;
      wr(A_CTRL, 8'h00);
   endtask

   task automatic t_priority;
      logic [15:0] v;
      wr16(A_RLD, 16'h5555);
      wr16(A_CNT, 16'hFFFF);
      wr(A_CTRL, 8'h01);
      @(negedge clk);
      tick_en = 1'b1; wr_en = 1'b1; addr = A_CNT + 3'd1; wr_data = 8'h0A;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
      rd16(A_CNT, v);  chk("R13 written byte wins", v, 16'h0A55);
      chk("R13 overflow still flagged", ovf_flag, 1'b1);
      wr(A_CTRL, 8'h00);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_regs();
      t_timer();
      t_counter();
      t_overflow();
      t_updown();
      t_capture();
      t_ext_reload();
      t_ext_off();
      t_clkout();
      t_priority();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule